// File: doc/BRIEF.md
# Configurable GPIO Pad Control

This block keeps the per-pin configuration of a general-purpose port and turns it into the three control lines each pad needs: a high-side drive enable, a low-side drive enable and a weak pull-up enable. Each pin can be set to analog or digital. A digital pin can be set to push-pull or open-drain. Each pin's output level comes either from a port latch or from a peripheral signal routed to that pin. Two global bits complete the configuration. One keeps the whole port parked until routing is enabled. The other removes every weak pull-up.

Software uses a small register port: a byte address, a write strobe, 8-bit write data and combinational read data. A write changes the pad controls in the cycle after the strobe. The pad levels come back through a two-stage synchronizer. The synchronized value is then masked, so analog pins read as zero. The analog circuitry, the pad transistors and the peripheral routing matrix sit outside the block.

Top module: `gpio_pad_ctl`

## Requirements
- R1: After reset, every configuration register reads 0 (analog, open-drain, latch low, routing off, pull-ups allowed). On every pin pad_drv_hi and pad_drv_lo are 0 and pad_pull is 1.
- R2: While the routing-enable bit (address 0x03, bit 0) is 0, every pin has both drive enables at 0. Its pull-up is 1 unless the pull-up disable bit is set. Mode and output value have no effect.
- R3: With routing on, a pin whose digital-mode bit (address 0x00) is 0 has its high drive, low drive and pull-up all at 0.
- R4: With routing on, a digital pin whose push-pull bit (address 0x01) is 1 drives high for an output value of 1 and low for an output value of 0.
- R5: With routing on, a digital pin whose push-pull bit is 0 never drives high. It drives low for an output value of 0, and both drivers are off for an output value of 1.
- R6: With routing on and the pull-up disable bit at 0, a digital pin's pull-up is 1 exactly when it is not driving low.
- R7: When the pull-up disable bit (address 0x03, bit 1) is 1, pad_pull is 0 on every pin, whatever the other settings are.
- R8: A read of address 0x04 returns the pad level, delayed by two clock edges, for digital pins and 0 for analog pins. The output value does not affect this read.
- R9: pad_drv_hi and pad_drv_lo are never both 1 on the same pin.
- R10: A write to address 0x00, 0x01, 0x02 or 0x03 changes the pad controls in the cycle after the write strobe. Reads of those addresses return the stored value. A write to any other address changes nothing.
- R11: A pin's output value is route_val when its route_sel bit is 1, and the port latch bit (address 0x02) otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| route_sel | input | 8 | Per pin: 1 takes the output value from route_val |
| route_val | input | 8 | Per-pin output value from a routed peripheral |
| pad_in | input | 8 | Sampled pad levels |
| pad_drv_hi | output | 8 | Per-pin high-side drive enable |
| pad_drv_lo | output | 8 | Per-pin low-side drive enable |
| pad_pull | output | 8 | Per-pin weak pull-up enable |

## Verification
The hardest case to reach from the ports is a pin whose settings disagree with each other. Examples are an analog pin with a peripheral selected, an open-drain pin at logic 1 while the pull-ups are disabled, and a push-pull pin held back by routing being off. Each of these needs several registers written in the right order. The stimulus writes random values into all four configuration registers and randomizes route_sel, route_val and pad_in between writes, so every pin meets many such combinations. Directed sequences then cover the reset state, each global bit alone, unmapped-address writes, and the exact two-edge delay of the readback path.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int AW = 8;
  localparam logic [AW-1:0] ADDR_DIGMODE = 8'h00;
  localparam logic [AW-1:0] ADDR_PPMODE  = 8'h01;
  localparam logic [AW-1:0] ADDR_LATCH   = 8'h02;
  localparam logic [AW-1:0] ADDR_GLOBAL  = 8'h03;
  localparam logic [AW-1:0] ADDR_PADIN   = 8'h04;
  localparam int GLB_ROUTE_BIT = 0;
  localparam int GLB_PULLOFF_BIT = 1;

  typedef struct packed {
    logic pull_off;
    logic route_en;
  } glb_cfg_t;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_pad_regs.sv
module gpio_pad_regs
  import gpio_pad_pkg::*;
#(
  parameter int PINS = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  input  logic [PINS-1:0] pad_sync,
  output logic [PINS-1:0] dig_mode,
  output logic [PINS-1:0] pp_mode,
  output logic [PINS-1:0] out_latch,
  output glb_cfg_t        glb,
  output logic [DW-1:0]   rdata
);
  logic [PINS-1:0] wbits;
  logic [PINS-1:0] pad_view;

  assign wbits = wdata[PINS-1:0];
  assign pad_view = pad_sync & dig_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_mode  <= '0;
      pp_mode   <= '0;
      out_latch <= '0;
      glb       <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_DIGMODE: dig_mode  <= wbits;
        ADDR_PPMODE:  pp_mode   <= wbits;
        ADDR_LATCH:   out_latch <= wbits;
        ADDR_GLOBAL: begin
          glb.route_en <= wdata[GLB_ROUTE_BIT];
          glb.pull_off <= wdata[GLB_PULLOFF_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_DIGMODE: rdata = DW'(dig_mode);
      ADDR_PPMODE:  rdata = DW'(pp_mode);
      ADDR_LATCH:   rdata = DW'(out_latch);
      ADDR_GLOBAL: begin
        rdata[GLB_ROUTE_BIT]   = glb.route_en;
        rdata[GLB_PULLOFF_BIT] = glb.pull_off;
      end
      ADDR_PADIN:   rdata = DW'(pad_view);
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic route_en,
  input  logic pull_off,
  input  logic digital,
  input  logic push_pull,
  input  logic latch_val,
  input  logic alt_sel,
  input  logic alt_val,
  output logic drv_hi,
  output logic drv_lo,
  output logic pull
);
  logic out_val;
  logic active;

  assign out_val = alt_sel ? alt_val : latch_val;
  assign active  = route_en & digital;

  always_comb begin
    drv_hi = active & push_pull & out_val;
    drv_lo = active & ~out_val;
    if (pull_off)       pull = 1'b0;
    else if (!route_en) pull = 1'b1;
    else                pull = digital & ~drv_lo;
  end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
  import gpio_pad_pkg::*;
#(
  parameter int PINS = 8,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [PINS-1:0] route_sel,
  input  logic [PINS-1:0] route_val,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_drv_hi,
  output logic [PINS-1:0] pad_drv_lo,
  output logic [PINS-1:0] pad_pull
);
  logic [PINS-1:0] dig_mode;
  logic [PINS-1:0] pp_mode;
  logic [PINS-1:0] out_latch;
  logic [PINS-1:0] pad_sync;
  glb_cfg_t        glb;
  logic            route_en;
  logic            pull_off;

  assign route_en = glb.route_en;
  assign pull_off = glb.pull_off;

  gpio_pad_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_out(pad_sync)
  );

  gpio_pad_regs #(.PINS(PINS), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .pad_sync(pad_sync), .dig_mode(dig_mode),
    .pp_mode(pp_mode), .out_latch(out_latch), .glb(glb), .rdata(reg_rdata)
  );

  generate
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      gpio_pin_cell u_cell (
        .route_en(route_en), .pull_off(pull_off),
        .digital(dig_mode[p]), .push_pull(pp_mode[p]),
        .latch_val(out_latch[p]), .alt_sel(route_sel[p]),
        .alt_val(route_val[p]), .drv_hi(pad_drv_hi[p]),
        .drv_lo(pad_drv_lo[p]), .pull(pad_pull[p])
      );
    end
  endgenerate
endmodule

// File: rtl/gpio_pad_chk.sv
module gpio_pad_chk
  import gpio_pad_pkg::*;
#(
  parameter int PINS = 8,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      reg_addr,
  input logic            reg_wr,
  input logic [DW-1:0]   reg_wdata,
  input logic [DW-1:0]   reg_rdata,
  input logic [PINS-1:0] pad_drv_hi,
  input logic [PINS-1:0] pad_drv_lo,
  input logic [PINS-1:0] pad_pull,
  input logic [PINS-1:0] dig_mode,
  input logic [PINS-1:0] pp_mode,
  input logic            route_en,
  input logic            pull_off
);
  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_drv_hi & pad_drv_lo) == '0);

  assert_parked_until_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !route_en |-> (pad_drv_hi == '0 && pad_drv_lo == '0 && pad_pull == (pull_off ? '0 : '1)));

  assert_analog_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    route_en |-> ((pad_drv_hi | pad_drv_lo | pad_pull) & ~dig_mode) == '0);

  assert_open_drain_no_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_drv_hi & ~pp_mode) == '0);

  assert_pull_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pull_off |-> pad_pull == '0);

  assert_analog_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_PADIN) |-> (reg_rdata[PINS-1:0] & ~dig_mode) == '0);

  assert_write_next_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_DIGMODE) |=> dig_mode == $past(reg_wdata[PINS-1:0]));
endmodule

bind gpio_pad_ctl gpio_pad_chk #(.PINS(PINS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_drv_hi(pad_drv_hi),
  .pad_drv_lo(pad_drv_lo), .pad_pull(pad_pull), .dig_mode(dig_mode),
  .pp_mode(pp_mode), .route_en(route_en), .pull_off(pull_off)
);

// File: tb/test_gpio_pad_ctl.sv
module test_gpio_pad_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] route_sel = '0;
  logic [7:0] route_val = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_drv_hi, pad_drv_lo, pad_pull;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [7:0] m_dig = '0, m_pp = '0, m_lat = '0;
  logic       m_route = 1'b0, m_poff = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pad_ctl i_gpio_pad_ctl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .route_sel(route_sel),
    .route_val(route_val), .pad_in(pad_in), .pad_drv_hi(pad_drv_hi),
    .pad_drv_lo(pad_drv_lo), .pad_pull(pad_pull)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_hi();
    logic [7:0] v = (m_lat & ~route_sel) | (route_val & route_sel);
    return m_route ? (m_dig & m_pp & v) : 8'h00;
  endfunction

  function automatic logic [7:0] exp_lo();
    logic [7:0] v = (m_lat & ~route_sel) | (route_val & route_sel);
    return m_route ? (m_dig & ~v) : 8'h00;
  endfunction

  function automatic logic [7:0] exp_pull();
    if (m_poff) return 8'h00;
    if (!m_route) return 8'hFF;
    return m_dig & ~exp_lo();
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      8'h00: m_dig = d;
      8'h01: m_pp = d;
      8'h02: m_lat = d;
      8'h03: begin m_route = d[0]; m_poff = d[1]; end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic check_pads(input string tag);
    #1;
    check({tag, " hi"}, pad_drv_hi, exp_hi());
    check({tag, " lo"}, pad_drv_lo, exp_lo());
    check({tag, " pull"}, pad_pull, exp_pull());
    check("R9 contention", pad_drv_hi & pad_drv_lo, 8'h00);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] r;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, r); check("R1 dig reg", r, 8'h00);
    rd(8'h01, r); check("R1 pp reg", r, 8'h00);
    rd(8'h02, r); check("R1 latch reg", r, 8'h00);
    rd(8'h03, r); check("R1 global reg", r, 8'h00);
    check("R1 hi", pad_drv_hi, 8'h00);
    check("R1 lo", pad_drv_lo, 8'h00);
    check("R1 pull", pad_pull, 8'hFF);

    // R2 parked: digital push-pull with mixed values, routing off
    wr(8'h00, 8'hFF); wr(8'h01, 8'hFF); wr(8'h02, 8'hA5);
    check_pads("R2 parked");
    check("R2 pull on", pad_pull, 8'hFF);

    // R10 write visible in the cycle after the strobe
    @(negedge clk);
    reg_addr = 8'h03; reg_wdata = 8'h01; reg_wr = 1'b1;
    #1 check("R10 not before edge", pad_drv_lo, 8'h00);
    @(negedge clk);
    reg_wr = 1'b0; m_route = 1'b1;
    #1 check("R10 after edge lo", pad_drv_lo, 8'h5A);
    check("R4 push-pull hi", pad_drv_hi, 8'hA5);

    // R5 open-drain
    wr(8'h01, 8'h00);
    check_pads("R5 open-drain");
    check("R6 pull on released pins", pad_pull, 8'hA5);

    // R3 analog half
    wr(8'h00, 8'h0F);
    check_pads("R3 analog");

    // R7 pull disable
    wr(8'h03, 8'h03);
    check_pads("R7 pull off");
    check("R7 none", pad_pull, 8'h00);
    wr(8'h03, 8'h01);

    // R11 peripheral select
    @(negedge clk);
    route_sel = 8'hF0; route_val = 8'h30;
    check_pads("R11 alt select");

    // R10 unmapped write ignored
    wr(8'h07, 8'hFF); wr(8'h05, 8'h00);
    rd(8'h00, r); check("R10 unmapped dig", r, 8'h0F);
    rd(8'h01, r); check("R10 unmapped pp", r, 8'h00);
    rd(8'h02, r); check("R10 unmapped latch", r, 8'hA5);
    rd(8'h03, r); check("R10 unmapped global", r, 8'h01);
    check_pads("R10 unmapped pads");

    // R8 readback latency and masking
    @(negedge clk);
    pad_in = 8'h00; repeat (3) @(negedge clk);
    pad_in = 8'hFF;
    @(negedge clk);
    rd(8'h04, r); check("R8 one edge still old", r, 8'h00);
    @(negedge clk);
    rd(8'h04, r); check("R8 two edges", r, 8'h0F);
    wr(8'h02, 8'h00);
    rd(8'h04, r); check("R8 not output value", r, 8'h0F);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned k = $urandom_range(0, 4);
      if (k == 4) begin
        @(negedge clk);
        route_sel = 8'($urandom); route_val = 8'($urandom);
        check_pads("R11 random");
      end else begin
        logic [7:0] d = 8'($urandom);
        if (k == 3) d = {6'b0, d[1:0]};
        wr(8'(k), d);
        check_pads("R4/R5/R6 random");
        rd(8'(k), r); check("R10 readback", r, d);
      end
      if (i % 25 == 0) begin
        logic [7:0] p = 8'($urandom);
        @(negedge clk);
        pad_in = p;
        @(negedge clk); @(negedge clk);
        rd(8'h04, r); check("R8 random", r, p & m_dig);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule